// File: doc/BRIEF.md
# Ethernet Pause and Backpressure Controller

This block sits next to an Ethernet MAC and turns one 8-bit host control register into flow-control actions.

- **Pause transmission.** The host can queue one-shot pause transmissions with a zero or a maximum timer. It can also let the block send them on its own as the receive buffer crosses its upper and lower marks. Each pause goes to the transmitter as a request with a 16-bit time value. The request is held until the transmitter returns a done strobe.
- **Half-duplex backpressure.** When the receive buffer is above the backpressure mark and a frame starts to arrive, the block raises a one-cycle jam request. One mode reacts to every frame. The other reacts only to frames whose destination address matched; the MAC reports that match in the same cycle as the frame-start strobe.
- **Received pause.** A received pause timer is loaded into a countdown that steps once per 512-bit-time slot tick. While flow control is enabled and the countdown is non-zero, the transmitter is held off.

Register bit layout, which the host relies on:

| Bit | Name | Behaviour |
|-----|------|-----------|
| 7 | send zero pause | set by writing 1 |
| 6 | send max pause | set by writing 1 |
| 5 | automatic watermark pause | writable |
| 4 | backpressure on any frame | writable |
| 3 | backpressure on address match | writable |
| 2 | received-pause seen | sticky, cleared by a read |
| 1 | received pause in force | live, read-only |
| 0 | flow-control enable | writable |

The register value is always visible on `reg_rdata`. The `reg_rd` input marks the cycle in which the host read it.

Top module: `fc_pause_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00 and `ptx_req`, `jam_req` and `tx_hold` are low.
- R2: Writing 1 to bit 7 raises `ptx_req` with `ptx_time` = 0x0000 within a few cycles. The request and its time value stay constant until `ptx_done`. In the cycle after `ptx_done`, `ptx_req` is low and bit 7 reads 0.
- R3: Writing 1 to bit 6 raises `ptx_req` with `ptx_time` = 0xFFFF. Bit 6 reads 0 after the matching `ptx_done`.
- R4: With bits 6 and 7 both set, the 0xFFFF pause is requested first and only bit 6 clears on its done. The 0x0000 pause is requested next and clears bit 7. `ptx_time` only ever carries 0x0000 or 0xFFFF.
- R5: With bit 5 set, a level above `fc_high_mark` requests a 0xFFFF pause. After that pause completes, a level below `fc_low_mark` requests a 0x0000 pause. A low level with no earlier 0xFFFF pause, or a level between the marks, requests nothing.
- R6: With bit 4 set in half duplex, `rx_frame_start` while `buf_level` > `bp_high_mark` gives a one-cycle `jam_req` in the next cycle. A level equal to the mark gives no jam. With bits 4 and 3 both clear there is no jam.
- R7: With bit 3 set and bit 4 clear, a jam is raised only if `rx_da_match` is high together with `rx_frame_start`. The same half-duplex and level conditions apply.
- R8: With `half_duplex` low, `jam_req` stays low in every mode.
- R9: `rx_pause_valid` sets bit 2. A cycle with `reg_rd` high clears bit 2 in the next cycle, unless `rx_pause_valid` is high in that same cycle, in which case bit 2 stays set.
- R10: `rx_pause_valid` loads `rx_pause_time` into the countdown. Each `slot_tick` decrements a non-zero count. Bit 1 reads 1 exactly while the count is non-zero, and a zero time ends a pause at once.
- R11: `tx_hold` is high only while bit 0 is set and bit 1 reads 1.
- R12: Writes do not change bits 2 and 1. Writing 0 to bit 7 or bit 6 does not withdraw a pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | host write strobe |
| reg_rd | input | 1 | host read strobe (clears bit 2) |
| reg_wdata | input | 8 | host write data |
| reg_rdata | output | 8 | current register value |
| buf_level | input | LVL_W | receive buffer fill level |
| bp_high_mark | input | LVL_W | backpressure threshold |
| fc_high_mark | input | LVL_W | automatic pause upper mark |
| fc_low_mark | input | LVL_W | automatic pause lower mark |
| half_duplex | input | 1 | link is half duplex |
| rx_frame_start | input | 1 | frame arrival strobe |
| rx_da_match | input | 1 | destination address matched, valid with frame start |
| rx_pause_valid | input | 1 | a pause frame was received |
| rx_pause_time | input | 16 | timer carried by the received pause |
| slot_tick | input | 1 | one pulse per 512 bit times |
| ptx_req | output | 1 | pause transmit request |
| ptx_time | output | 16 | time value for the requested pause |
| ptx_done | input | 1 | transmitter finished the pause frame |
| jam_req | output | 1 | one-cycle jam request |
| tx_hold | output | 1 | transmitter must hold off |

## Verification
The assertions check the following on every cycle:
- a pause request stays constant until done, drops only after done, and carries only the two legal time values;
- a jam only follows a frame start above the backpressure mark in half duplex;
- the seen status falls only after a read;
- the live status rises only after a received pause;
- the hold follows a fresh non-zero pause when flow control is enabled.

The bench scenarios cover what needs a sequence or a missing event:
- the service order of two queued requests;
- the rule that the automatic zero pause needs an earlier maximum pause;
- the address-match and duplex qualification of the jam;
- the countdown length;
- the cases where a write or a low level must have no effect.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int TIME_W = 16;
    localparam logic [TIME_W-1:0] PAUSE_MAX  = '1;
    localparam logic [TIME_W-1:0] PAUSE_ZERO = '0;

    // Host register layout, bit 7 first.
    typedef struct packed {
        logic req_zero;
        logic req_max;
        logic auto_en;
        logic bp_any;
        logic bp_match;
        logic rx_seen;
        logic rx_live;
        logic fc_en;
    } ctl_reg_t;

    typedef enum logic [1:0] {
        SRC_HOST_MAX,
        SRC_HOST_ZERO,
        SRC_AUTO_XOFF,
        SRC_AUTO_XON
    } pause_src_e;

    function automatic logic [TIME_W-1:0] src_time(pause_src_e s);
        return (s == SRC_HOST_MAX || s == SRC_AUTO_XOFF) ? PAUSE_MAX : PAUSE_ZERO;
    endfunction

endpackage

// File: rtl/fc_ctl_reg.sv
module fc_ctl_reg
    import fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    input  logic       rx_pause_valid,
    input  logic       rx_live,
    input  logic       clr_max,
    input  logic       clr_zero,
    output ctl_reg_t   ctl
);
    logic req_zero, req_max, auto_en, bp_any, bp_match, rx_seen, fc_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_zero <= 1'b0;
            req_max  <= 1'b0;
            auto_en  <= 1'b0;
            bp_any   <= 1'b0;
            bp_match <= 1'b0;
            rx_seen  <= 1'b0;
            fc_en    <= 1'b0;
        end else begin
            if (wr) begin
                auto_en  <= wdata[5];
                bp_any   <= wdata[4];
                bp_match <= wdata[3];
                fc_en    <= wdata[0];
            end
            // one-shot requests: write-one-to-set, cleared on completion
            req_zero <= (req_zero & ~clr_zero) | (wr & wdata[7]);
            req_max  <= (req_max  & ~clr_max)  | (wr & wdata[6]);
            rx_seen  <= rx_pause_valid | (rx_seen & ~rd);
        end
    end

    always_comb begin
        ctl.req_zero = req_zero;
        ctl.req_max  = req_max;
        ctl.auto_en  = auto_en;
        ctl.bp_any   = bp_any;
        ctl.bp_match = bp_match;
        ctl.rx_seen  = rx_seen;
        ctl.rx_live  = rx_live;
        ctl.fc_en    = fc_en;
    end
endmodule

// File: rtl/fc_pause_tx.sv
module fc_pause_tx
    import fc_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_max,
    input  logic              req_zero,
    input  logic              auto_en,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  high_mark,
    input  logic [LVL_W-1:0]  low_mark,
    input  logic              done,
    output logic              busy,
    output logic [TIME_W-1:0] time_val,
    output logic              clr_max,
    output logic              clr_zero
);
    pause_src_e src, pick;
    logic       have_pick, xoff_sent;

    // fixed priority: host max, host zero, automatic max, automatic zero
    always_comb begin
        have_pick = 1'b1;
        pick      = SRC_HOST_MAX;
        if (req_max)                                  pick = SRC_HOST_MAX;
        else if (req_zero)                            pick = SRC_HOST_ZERO;
        else if (auto_en && !xoff_sent && level > high_mark) pick = SRC_AUTO_XOFF;
        else if (auto_en && xoff_sent && level < low_mark)   pick = SRC_AUTO_XON;
        else                                          have_pick = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            src       <= SRC_HOST_MAX;
            time_val  <= PAUSE_ZERO;
            xoff_sent <= 1'b0;
        end else begin
            if (!busy) begin
                if (have_pick) begin
                    busy     <= 1'b1;
                    src      <= pick;
                    time_val <= src_time(pick);
                end
            end else if (done) begin
                busy <= 1'b0;
                if (src == SRC_AUTO_XOFF) xoff_sent <= 1'b1;
                if (src == SRC_AUTO_XON)  xoff_sent <= 1'b0;
            end
            if (!auto_en) xoff_sent <= 1'b0;
        end
    end

    assign clr_max  = busy && done && (src == SRC_HOST_MAX);
    assign clr_zero = busy && done && (src == SRC_HOST_ZERO);
endmodule

// File: rtl/fc_rx_timer.sv
module fc_rx_timer
    import fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    input  logic              tick,
    input  logic              fc_en,
    output logic              live,
    output logic              hold
);
    logic [TIME_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (load)                count <= load_val;
        else if (tick && count != 0)  count <= count - 1'b1;
    end

    assign live = (count != '0);
    assign hold = fc_en & live;
endmodule

// File: rtl/fc_jam.sv
module fc_jam #(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_duplex,
    input  logic             bp_any,
    input  logic             bp_match,
    input  logic             frame_start,
    input  logic             da_match,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mark,
    output logic             jam
);
    logic hit;

    assign hit = half_duplex && frame_start && (level > mark)
              && (bp_any || (bp_match && da_match));

    always_ff @(posedge clk) begin
        if (rst) jam <= 1'b0;
        else     jam <= hit;
    end
endmodule

// File: rtl/fc_pause_ctrl.sv
module fc_pause_ctrl
    import fc_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [LVL_W-1:0]  buf_level,
    input  logic [LVL_W-1:0]  bp_high_mark,
    input  logic [LVL_W-1:0]  fc_high_mark,
    input  logic [LVL_W-1:0]  fc_low_mark,
    input  logic              half_duplex,
    input  logic              rx_frame_start,
    input  logic              rx_da_match,
    input  logic              rx_pause_valid,
    input  logic [TIME_W-1:0] rx_pause_time,
    input  logic              slot_tick,
    output logic              ptx_req,
    output logic [TIME_W-1:0] ptx_time,
    input  logic              ptx_done,
    output logic              jam_req,
    output logic              tx_hold
);
    ctl_reg_t ctl;
    logic     clr_max, clr_zero, rx_live;

    fc_ctl_reg u_reg (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
        .rx_pause_valid(rx_pause_valid), .rx_live(rx_live),
        .clr_max(clr_max), .clr_zero(clr_zero), .ctl(ctl)
    );

    fc_pause_tx #(.LVL_W(LVL_W)) u_ptx (
        .clk(clk), .rst(rst), .req_max(ctl.req_max), .req_zero(ctl.req_zero),
        .auto_en(ctl.auto_en), .level(buf_level), .high_mark(fc_high_mark),
        .low_mark(fc_low_mark), .done(ptx_done), .busy(ptx_req),
        .time_val(ptx_time), .clr_max(clr_max), .clr_zero(clr_zero)
    );

    fc_rx_timer u_rxt (
        .clk(clk), .rst(rst), .load(rx_pause_valid), .load_val(rx_pause_time),
        .tick(slot_tick), .fc_en(ctl.fc_en), .live(rx_live), .hold(tx_hold)
    );

    fc_jam #(.LVL_W(LVL_W)) u_jam (
        .clk(clk), .rst(rst), .half_duplex(half_duplex), .bp_any(ctl.bp_any),
        .bp_match(ctl.bp_match), .frame_start(rx_frame_start),
        .da_match(rx_da_match), .level(buf_level), .mark(bp_high_mark),
        .jam(jam_req)
    );

    assign reg_rdata = ctl;
endmodule

// File: rtl/fc_pause_ctrl_chk.sv
module fc_pause_ctrl_chk
    import fc_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic [7:0]        reg_rdata,
    input logic [LVL_W-1:0]  buf_level,
    input logic [LVL_W-1:0]  bp_high_mark,
    input logic              half_duplex,
    input logic              rx_frame_start,
    input logic              rx_pause_valid,
    input logic [TIME_W-1:0] rx_pause_time,
    input logic              ptx_req,
    input logic [TIME_W-1:0] ptx_time,
    input logic              ptx_done,
    input logic              jam_req,
    input logic              tx_hold
);
    // R2
    ptx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ptx_req && !ptx_done |=> ptx_req && $stable(ptx_time));

    // R2
    ptx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ptx_req) |-> $past(ptx_done));

    // R4
    ptx_value_chk: assert property (@(posedge clk) disable iff (rst)
        ptx_req |-> (ptx_time == PAUSE_ZERO || ptx_time == PAUSE_MAX));

    // R6
    jam_cause_chk: assert property (@(posedge clk) disable iff (rst)
        jam_req |-> $past(rx_frame_start) && $past(buf_level > bp_high_mark));

    // R8
    jam_duplex_chk: assert property (@(posedge clk) disable iff (rst)
        jam_req |-> $past(half_duplex));

    // R9
    seen_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_rdata[2]) |-> $past(reg_rd));

    // R10
    live_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rdata[1]) |-> $past(rx_pause_valid));

    // R11
    hold_on_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rx_pause_valid) && $past(rx_pause_time != 0) && $past(reg_rdata[0])
        && reg_rdata[0] |-> tx_hold);
endmodule

bind fc_pause_ctrl fc_pause_ctrl_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/fc_pause_ctrl_bench.sv
module fc_pause_ctrl_bench;
    localparam int LVL_W = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic [LVL_W-1:0] buf_level = 0;
    logic [LVL_W-1:0] bp_high_mark = 10'd100;
    logic [LVL_W-1:0] fc_high_mark = 10'd200;
    logic [LVL_W-1:0] fc_low_mark  = 10'd100;
    logic        half_duplex = 0, rx_frame_start = 0, rx_da_match = 0;
    logic        rx_pause_valid = 0, slot_tick = 0, ptx_done = 0;
    logic [15:0] rx_pause_time = 0;
    logic        ptx_req, jam_req, tx_hold;
    logic [15:0] ptx_time;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fc_pause_ctrl #(.LVL_W(LVL_W)) u_fc_pause_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_level(buf_level),
        .bp_high_mark(bp_high_mark), .fc_high_mark(fc_high_mark),
        .fc_low_mark(fc_low_mark), .half_duplex(half_duplex),
        .rx_frame_start(rx_frame_start), .rx_da_match(rx_da_match),
        .rx_pause_valid(rx_pause_valid), .rx_pause_time(rx_pause_time),
        .slot_tick(slot_tick), .ptx_req(ptx_req), .ptx_time(ptx_time),
        .ptx_done(ptx_done), .jam_req(jam_req), .tx_hold(tx_hold)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected<50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // jam vectors: {half_duplex, bp_any, bp_match, da_match, level_above, expect}
    localparam logic [5:0] JAM_VEC [8] = '{
        6'b1_1_0_0_1_1,   // R6 any frame above mark
        6'b1_1_0_0_0_0,   // R6 level equal to mark
        6'b0_1_0_0_1_0,   // R8 full duplex, any mode
        6'b1_0_1_1_1_1,   // R7 match mode with match
        6'b1_0_1_0_1_0,   // R7 match mode without match
        6'b0_0_1_1_1_0,   // R8 full duplex, match mode
        6'b1_0_0_1_1_0,   // R6 both modes off
        6'b1_1_1_0_1_1    // R6 any mode dominates
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic host_write(input logic [7:0] d);
        reg_wr = 1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic host_read();
        reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_req(input string req);
        for (int k = 0; k < 20 && !ptx_req; k++) @(negedge clk);
        check(ptx_req == 1'b1, req, ptx_req, 1);
    endtask

    task automatic finish_pause();
        ptx_done = 1;
        @(negedge clk);
        ptx_done = 0;
    endtask

    task automatic rx_pause(input logic [15:0] t, input bit with_rd);
        rx_pause_valid = 1; rx_pause_time = t; reg_rd = with_rd;
        @(negedge clk);
        rx_pause_valid = 0; reg_rd = 0;
    endtask

    task automatic tick();
        slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
    endtask

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check(reg_rdata == 8'h00, "R1 register", reg_rdata, 8'h00);
        check({ptx_req, jam_req, tx_hold} == 3'b000, "R1 outputs",
              {ptx_req, jam_req, tx_hold}, 0);

        // R12 status bits not writable
        host_write(8'h06);
        check(reg_rdata == 8'h00, "R12 status write", reg_rdata, 8'h00);

        // jam table walk
        for (int i = 0; i < 8; i++) begin
            logic [5:0] v;
            v = JAM_VEC[i];
            half_duplex = v[5];
            host_write({3'b000, v[4], v[3], 3'b000});
            rx_da_match = v[2];
            buf_level = v[1] ? 10'd150 : 10'd100;
            rx_frame_start = 1;
            @(negedge clk);
            rx_frame_start = 0;
            check(jam_req == v[0], $sformatf("R6 R7 R8 vector %0d", i), jam_req, v[0]);
            @(negedge clk);
            check(jam_req == 1'b0, "R6 jam single cycle", jam_req, 0);
        end
        half_duplex = 0; rx_da_match = 0; buf_level = 10'd150;
        host_write(8'h00);

        // R2 zero pause, R12 writing 0 does not cancel
        host_write(8'h80);
        host_write(8'h00);
        check(reg_rdata[7] == 1'b1, "R12 pending kept", reg_rdata[7], 1);
        wait_req("R2 request");
        check(ptx_time == 16'h0000, "R2 time", ptx_time, 16'h0000);
        idle(3);
        check(ptx_req && ptx_time == 16'h0000, "R2 held", ptx_req, 1);
        finish_pause();
        check(ptx_req == 1'b0, "R2 drop", ptx_req, 0);
        check(reg_rdata[7] == 1'b0, "R2 self clear", reg_rdata[7], 0);

        // R3 max pause
        host_write(8'h40);
        wait_req("R3 request");
        check(ptx_time == 16'hFFFF, "R3 time", ptx_time, 16'hFFFF);
        finish_pause();
        check(reg_rdata[6] == 1'b0, "R3 self clear", reg_rdata[6], 0);
        idle(3);
        check(ptx_req == 1'b0, "R3 no repeat", ptx_req, 0);

        // R4 both at once
        host_write(8'hC0);
        wait_req("R4 first request");
        check(ptx_time == 16'hFFFF, "R4 max first", ptx_time, 16'hFFFF);
        finish_pause();
        check(reg_rdata[7:6] == 2'b10, "R4 only max cleared", reg_rdata[7:6], 2'b10);
        wait_req("R4 second request");
        check(ptx_time == 16'h0000, "R4 zero second", ptx_time, 16'h0000);
        finish_pause();
        check(reg_rdata[7:6] == 2'b00, "R4 both cleared", reg_rdata[7:6], 2'b00);

        // R5 automatic watermarks
        buf_level = 10'd50;
        host_write(8'h20);
        idle(5);
        check(ptx_req == 1'b0, "R5 no zero without prior max", ptx_req, 0);
        buf_level = 10'd250;
        wait_req("R5 high request");
        check(ptx_time == 16'hFFFF, "R5 high time", ptx_time, 16'hFFFF);
        finish_pause();
        buf_level = 10'd150;
        idle(5);
        check(ptx_req == 1'b0, "R5 between marks", ptx_req, 0);
        buf_level = 10'd50;
        wait_req("R5 low request");
        check(ptx_time == 16'h0000, "R5 low time", ptx_time, 16'h0000);
        finish_pause();
        idle(5);
        check(ptx_req == 1'b0, "R5 no second zero", ptx_req, 0);
        host_write(8'h00);

        // R9 R10 R11 received pause
        host_write(8'h01);
        rx_pause(16'd3, 0);
        check(reg_rdata[2:1] == 2'b11, "R9 R10 status set", reg_rdata[2:1], 2'b11);
        check(tx_hold == 1'b1, "R11 hold active", tx_hold, 1);
        tick(); tick();
        check(reg_rdata[1] == 1'b1, "R10 still live after 2 ticks", reg_rdata[1], 1);
        tick();
        check(reg_rdata[1] == 1'b0, "R10 expired after 3 ticks", reg_rdata[1], 0);
        check(tx_hold == 1'b0, "R11 hold released", tx_hold, 0);
        check(reg_rdata[2] == 1'b1, "R9 sticky", reg_rdata[2], 1);
        host_read();
        check(reg_rdata[2] == 1'b0, "R9 read clears", reg_rdata[2], 0);
        rx_pause(16'd2, 1);
        check(reg_rdata[2] == 1'b1, "R9 set beats read", reg_rdata[2], 1);
        rx_pause(16'd0, 0);
        check(reg_rdata[1] == 1'b0, "R10 zero time ends pause", reg_rdata[1], 0);
        host_write(8'h00);
        rx_pause(16'd5, 0);
        check(reg_rdata[1] == 1'b1, "R10 live", reg_rdata[1], 1);
        check(tx_hold == 1'b0, "R11 no hold when disabled", tx_hold, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule